// File: doc/BRIEF.md
# Flow-Through Synchronous Burst SRAM

This block models a single-clock synchronous static RAM whose reads flow through. There is no output pipeline register: the word at the address captured on a rising edge drives the data output during the cycle that follows that edge. Every control input is sampled on the rising clock edge. These inputs are three chip enables, a processor address strobe, a controller address strobe, a burst-advance input and a set of write enables. From them the block decides, on each edge, to do one of four things: deselect, start a burst at the external address, step the burst to its next address, or hold it at the current address.

A write can cover all lanes or a chosen set of byte lanes. The array is split into lanes of eight data bits plus one parity bit. A two-bit burst counter walks through four addresses in linear or interleaved order. Output enable gates the data output asynchronously. A sleep input freezes the block and keeps every stored value intact.

Top module: `fts_sram`

## Requirements
- R1: The chip counts as selected only when `ce1_n`=0, `ce2`=1 and `ce3_n`=0. Any other combination on a burst-start cycle deselects the chip, and `dq_drive` is 0 from that edge on.
- R2: When `pstb_n`=0 and the chip is selected, a read burst starts at `addr`. All write enables are ignored on that edge, and the array is left unchanged.
- R3: When `pstb_n`=0 and `ce1_n`=1, the processor strobe is ignored. The edge is then decoded from `cstb_n` and `adv_n` alone.
- R4: When `pstb_n`=1, `cstb_n`=0 and the chip is selected, a burst starts at `addr`. It is a write when the write decode of R8 is active and a read otherwise.
- R5: When both strobes are 1, `adv_n`=0 steps the burst to its next address and `adv_n`=1 holds the current address. Chip enables are ignored on these edges, and the write decode picks read or write.
- R6: The burst changes only the low two address bits. With `lin_mode`=1, step n uses (start+n) mod 4. With `lin_mode`=0, it uses start XOR n.
- R7: Once deselected, the chip stays deselected through step and hold edges until a new burst start.
- R8: The write decode is active when `gw_n`=0, or when `bwe_n`=0 and any `bw_n` bit is 0. With `gw_n`=0, all lanes are written.
- R9: With `gw_n`=1 and `bwe_n`=0, lane k is written only if `bw_n[k]`=0. Lane k is `dq_in[9k+8:9k]`.
- R10: Reads flow through. After a read edge, `dq_out` carries the word at the current burst address within the same cycle. Write data is captured on the same edge as its address.
- R11: `dq_drive` is 0 during write cycles and while deselected, and it follows `oe_n` without waiting for a clock. When `dq_drive` is 0, `dq_out` is all zeros.
- R12: Setting `sleep`=1 freezes the block from that edge on. The array and the burst state are kept, outputs are off and all controls are ignored. The first edge after `sleep` returns to 0 is also ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of control state |
| ce1_n | input | 1 | First active-low chip enable |
| ce2 | input | 1 | Active-high chip enable |
| ce3_n | input | 1 | Second active-low chip enable |
| pstb_n | input | 1 | Processor address strobe, active low |
| cstb_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write master enable, active low |
| bw_n | input | LANES | Per-lane write enables, active low |
| lin_mode | input | 1 | Burst order: 1 linear, 0 interleaved |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Power-down request |
| addr | input | ADDR_W | External word address |
| dq_in | input | LANES*LANE_W | Write data |
| dq_out | output | LANES*LANE_W | Read data, zero when not driven |
| dq_drive | output | 1 | Output bus is driven |

## Verification
The hardest case to reach is the return from sleep. A burst must be in progress when `sleep` rises. While the block is asleep, controls must be applied that would write and restart the burst if they were obeyed. The edge on which `sleep` falls must also carry such controls. To cover this, the stimulus puts a write start with a global write on the inputs throughout the sleep window and on that falling edge. It then reads the same burst address, and also the address that start would have written, to show that neither was touched.

// File: rtl/fts_pkg.sv
package fts_pkg;

  typedef enum logic [1:0] {
    CMD_DESEL,
    CMD_START,
    CMD_NEXT,
    CMD_STAY
  } cmd_e;

  // chip is selected only with all three enables in their active state
  function automatic logic chip_on(logic e1_n, logic e2, logic e3_n);
    return !e1_n && e2 && !e3_n;
  endfunction

  // low two address bits of burst step 'step' from start value 'start'
  function automatic logic [1:0] burst_low(logic [1:0] start, logic [1:0] step,
                                           logic linear);
    return linear ? 2'(start + step) : (start ^ step);
  endfunction

endpackage

// File: rtl/fts_cmd_decode.sv
module fts_cmd_decode
  import fts_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             pstb_n,
  input  logic             cstb_n,
  input  logic             adv_n,
  input  logic             ce1_n,
  input  logic             ce2,
  input  logic             ce3_n,
  input  logic             gw_n,
  input  logic             bwe_n,
  input  logic [LANES-1:0] bw_n,
  output cmd_e             cmd,
  output logic             proc_start,
  output logic             wr_req,
  output logic [LANES-1:0] lane_we
);

  logic sel;

  always_comb begin
    sel        = chip_on(ce1_n, ce2, ce3_n);
    proc_start = 1'b0;
    if (!pstb_n && !ce1_n) begin
      cmd        = sel ? CMD_START : CMD_DESEL;
      proc_start = sel;
    end else if (!cstb_n) begin
      cmd = sel ? CMD_START : CMD_DESEL;
    end else begin
      cmd = adv_n ? CMD_STAY : CMD_NEXT;
    end
  end

  always_comb begin
    if (!gw_n)       lane_we = '1;
    else if (!bwe_n) lane_we = ~bw_n;
    else             lane_we = '0;
    wr_req = |lane_we;
  end

endmodule

// File: rtl/fts_burst_ctr.sv
module fts_burst_ctr
  import fts_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic              lin_mode,
  input  logic [ADDR_W-1:0] load_addr,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [ADDR_W-1:0] nxt_addr
);

  logic [ADDR_W-1:0] base_q;
  logic [1:0]        cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else if (load) begin
      base_q <= load_addr;
      cnt_q  <= '0;
    end else if (step) begin
      cnt_q <= cnt_q + 2'd1;
    end
  end

  assign cur_addr = {base_q[ADDR_W-1:2], burst_low(base_q[1:0], cnt_q, lin_mode)};
  assign nxt_addr = {base_q[ADDR_W-1:2],
                     burst_low(base_q[1:0], cnt_q + 2'd1, lin_mode)};

endmodule

// File: rtl/fts_lane_array.sv
module fts_lane_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    we,
  input  logic [LANES-1:0]        lane_we,
  input  logic [ADDR_W-1:0]       waddr,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic [ADDR_W-1:0]       raddr,
  output logic [LANES*LANE_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (we && lane_we[g]) mem[waddr] <= wdata[g*LANE_W +: LANE_W];
    end

    assign rdata[g*LANE_W +: LANE_W] = mem[raddr];
  end

endmodule

// File: rtl/fts_sram.sv
module fts_sram
  import fts_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ce1_n,
  input  logic                    ce2,
  input  logic                    ce3_n,
  input  logic                    pstb_n,
  input  logic                    cstb_n,
  input  logic                    adv_n,
  input  logic                    gw_n,
  input  logic                    bwe_n,
  input  logic [LANES-1:0]        bw_n,
  input  logic                    lin_mode,
  input  logic                    oe_n,
  input  logic                    sleep,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] dq_in,
  output logic [LANES*LANE_W-1:0] dq_out,
  output logic                    dq_drive
);

  localparam int DATA_W = LANES * LANE_W;

  cmd_e              cmd;
  logic              proc_start, wr_req;
  logic [LANES-1:0]  lane_we;
  logic              busy_q, wr_q, asleep_q;
  logic [ADDR_W-1:0] cur_addr, nxt_addr, waddr;
  logic [DATA_W-1:0] rdata;

  // named events, also observed by the checker
  logic frozen, start_evt, desel_evt, adv_evt, stay_evt, write_evt;

  fts_cmd_decode #(.LANES(LANES)) u_dec (
    .pstb_n(pstb_n), .cstb_n(cstb_n), .adv_n(adv_n),
    .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
    .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n),
    .cmd(cmd), .proc_start(proc_start), .wr_req(wr_req), .lane_we(lane_we)
  );

  assign frozen    = sleep | asleep_q;
  assign start_evt = !frozen && cmd == CMD_START;
  assign desel_evt = !frozen && cmd == CMD_DESEL;
  assign adv_evt   = !frozen && cmd == CMD_NEXT && busy_q;
  assign stay_evt  = !frozen && cmd == CMD_STAY && busy_q;
  assign write_evt = wr_req && ((start_evt && !proc_start) || adv_evt || stay_evt);
  assign waddr     = start_evt ? addr : (adv_evt ? nxt_addr : cur_addr);

  fts_burst_ctr #(.ADDR_W(ADDR_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .load(start_evt), .step(adv_evt),
    .lin_mode(lin_mode), .load_addr(addr),
    .cur_addr(cur_addr), .nxt_addr(nxt_addr)
  );

  fts_lane_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
    .clk(clk), .we(write_evt), .lane_we(lane_we), .waddr(waddr),
    .wdata(dq_in), .raddr(cur_addr), .rdata(rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      wr_q     <= 1'b0;
      asleep_q <= 1'b0;
    end else begin
      asleep_q <= sleep;
      if (start_evt) begin
        busy_q <= 1'b1;
        wr_q   <= wr_req && !proc_start;
      end else if (desel_evt) begin
        busy_q <= 1'b0;
        wr_q   <= 1'b0;
      end else if (adv_evt || stay_evt) begin
        wr_q <= wr_req;
      end
    end
  end

  assign dq_drive = busy_q && !wr_q && !oe_n && !asleep_q;
  assign dq_out   = dq_drive ? rdata : '0;

endmodule

// File: rtl/fts_sram_chk.sv
module fts_sram_chk #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              oe_n,
  input logic              pstb_n,
  input logic              cstb_n,
  input logic              ce1_n,
  input logic              dq_drive,
  input logic              frozen,
  input logic              asleep_q,
  input logic              busy_q,
  input logic              wr_q,
  input logic              start_evt,
  input logic              desel_evt,
  input logic              stay_evt,
  input logic              proc_start,
  input logic [ADDR_W-1:0] addr,
  input logic [ADDR_W-1:0] cur_addr
);

  assert_start_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> busy_q && cur_addr == $past(addr));

  assert_proc_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_evt && proc_start) |=> !wr_q);

  assert_desel_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    desel_evt |=> !busy_q && !dq_drive);

  assert_desel_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !start_evt) |=> !busy_q);

  assert_stay_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    stay_evt |=> $stable(cur_addr));

  assert_freeze_R12: assert property (@(posedge clk) disable iff (!rst_n)
    frozen |=> $stable(cur_addr) && $stable(busy_q));

  assert_asleep_off_R12: assert property (@(posedge clk) disable iff (!rst_n)
    asleep_q |-> !dq_drive);

  assert_drive_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
    dq_drive |-> !oe_n && !wr_q && busy_q);

  assert_ce1_ignores_pstb_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!pstb_n && ce1_n && cstb_n && busy_q && !frozen) |-> !start_evt && !desel_evt);

endmodule

bind fts_sram fts_sram_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .oe_n(oe_n), .pstb_n(pstb_n), .cstb_n(cstb_n),
  .ce1_n(ce1_n), .dq_drive(dq_drive), .frozen(frozen), .asleep_q(asleep_q),
  .busy_q(busy_q), .wr_q(wr_q), .start_evt(start_evt), .desel_evt(desel_evt),
  .stay_evt(stay_evt), .proc_start(proc_start), .addr(addr), .cur_addr(cur_addr)
);

// File: tb/sim_fts_sram.sv
`timescale 1ns/1ps
module sim_fts_sram;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce1_n, ce2, ce3_n, pstb_n, cstb_n, adv_n, gw_n, bwe_n, lin_mode, oe_n, sleep;
  logic [3:0]  bw_n;
  logic [5:0]  addr;
  logic [35:0] dq_in;
  logic [35:0] dq_out;
  logic        dq_drive;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  fts_sram u0 (
    .clk(clk), .rst_n(rst_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
    .pstb_n(pstb_n), .cstb_n(cstb_n), .adv_n(adv_n), .gw_n(gw_n), .bwe_n(bwe_n),
    .bw_n(bw_n), .lin_mode(lin_mode), .oe_n(oe_n), .sleep(sleep), .addr(addr),
    .dq_in(dq_in), .dq_out(dq_out), .dq_drive(dq_drive)
  );

  // ---------------- reference model ----------------
  logic [35:0] m_mem [64];
  bit m_busy, m_wr, m_sleep;
  int m_base, m_step;

  function automatic int eff(int base, int step, bit lin);
    int lo = base % 4;
    int hi = base - lo;
    if (lin) lo = (lo + step) % 4;
    else     lo = lo ^ (step % 4);
    return hi + lo;
  endfunction

  task automatic mwrite(int a);
    for (int k = 0; k < 4; k++)
      if (!gw_n || !bw_n[k]) m_mem[a][k*9 +: 9] = dq_in[k*9 +: 9];
  endtask

  task automatic model_edge();
    bit on, anyw;
    if (!rst_n) begin
      m_busy = 0; m_wr = 0; m_sleep = 0; m_base = 0; m_step = 0;
      return;
    end
    if (!(sleep || m_sleep)) begin
      on   = !ce1_n && ce2 && !ce3_n;
      anyw = !gw_n || (!bwe_n && bw_n != 4'hF);
      if (!pstb_n && !ce1_n) begin
        if (on) begin m_busy = 1; m_wr = 0; m_base = addr; m_step = 0; end
        else m_busy = 0;
      end else if (!cstb_n) begin
        if (on) begin
          m_busy = 1; m_wr = anyw; m_base = addr; m_step = 0;
          if (anyw) mwrite(addr);
        end else m_busy = 0;
      end else if (m_busy) begin
        if (!adv_n) m_step++;
        m_wr = anyw;
        if (anyw) mwrite(eff(m_base, m_step, lin_mode));
      end
    end
    m_sleep = sleep;
  endtask

  task automatic check(bit ok, string tag, string what, logic [35:0] act, logic [35:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    logic        exp_d;
    logic [35:0] exp_q;
    exp_d = rst_n && m_busy && !m_wr && !oe_n && !m_sleep;
    exp_q = exp_d ? m_mem[eff(m_base, m_step, lin_mode)] : 36'd0;
    check(dq_drive === exp_d, tag, "drive", 36'(dq_drive), 36'(exp_d));
    check(dq_out === exp_q, tag, "data", dq_out, exp_q);
  endtask

  task automatic cyc(string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare(tag);
  endtask

  task automatic quiet();
    ce1_n = 0; ce2 = 1; ce3_n = 0;
    pstb_n = 1; cstb_n = 1; adv_n = 1;
    gw_n = 1; bwe_n = 1; bw_n = 4'hF;
    oe_n = 0; sleep = 0;
  endtask

  function automatic logic [35:0] pat(int a, int n);
    return 36'(a * 36'h1_3579_BDF + n * 36'h2468_ACE + 36'h5A5);
  endfunction

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL R10 watchdog actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) m_mem[i] = '0;
    quiet(); lin_mode = 1; addr = 0; dq_in = 0;
    cyc("R11 reset");
    cyc("R11 reset");
    rst_n = 1;
    cyc("R7 idle after reset");

    // R8: fill array with global-write bursts (R6 linear order)
    for (int b = 0; b < 16; b++) begin
      cstb_n = 0; gw_n = 0; addr = 6'(b * 4 + (b % 4)); dq_in = pat(b, 0);
      cyc("R8 global write start");
      cstb_n = 1; adv_n = 0;
      for (int i = 1; i < 4; i++) begin
        dq_in = pat(b, i);
        cyc("R8 global write step");
      end
      quiet();
    end

    // R2: processor start reads, write enables ignored
    pstb_n = 0; addr = 6'd5; gw_n = 0; dq_in = 36'hF_FFFF_FFFF;
    cyc("R2 proc start read");
    pstb_n = 1; gw_n = 1; adv_n = 0;
    for (int i = 0; i < 3; i++) cyc("R10 R6 linear read step");
    adv_n = 1;
    cyc("R5 hold"); cyc("R5 hold");

    // R3: pstb low with ce1_n high continues burst
    pstb_n = 0; ce1_n = 1; adv_n = 0;
    cyc("R3 pstb ignored");
    pstb_n = 1; ce1_n = 0;

    // R5: chip enables ignored on step
    ce2 = 0; adv_n = 0;
    cyc("R5 enables ignored");
    ce2 = 1; adv_n = 1;

    // R6 interleaved
    lin_mode = 0; pstb_n = 0; addr = 6'd22;
    cyc("R6 interleaved start");
    pstb_n = 1; adv_n = 0;
    for (int i = 0; i < 3; i++) cyc("R6 interleaved step");
    adv_n = 1; lin_mode = 1;

    // R9: lanes 0 and 2 only
    cstb_n = 0; addr = 6'd9; bwe_n = 0; bw_n = 4'b1010; dq_in = 36'h1_2345_6789;
    cyc("R9 lane write");
    cstb_n = 1; bwe_n = 1; bw_n = 4'hF;
    cyc("R9 readback after write");
    // R8: byte enables without master enable decode as read
    cstb_n = 0; addr = 6'd9; bw_n = 4'h0; dq_in = 36'h0;
    cyc("R8 no master means read");
    cstb_n = 1; bw_n = 4'hF;
    cyc("R4 read start held");
    // R4: write step then read step in same burst
    adv_n = 0; gw_n = 0; dq_in = 36'hA_BCDE_F012;
    cyc("R4 write step");
    gw_n = 1; adv_n = 1;
    cyc("R10 read after write");

    // R11: asynchronous output enable
    oe_n = 1; #1;
    check(dq_drive === 1'b0, "R11", "oe off", 36'(dq_drive), 36'd0);
    oe_n = 0; #0.5;
    check(dq_drive === 1'b1, "R11", "oe on", 36'(dq_drive), 36'd1);
    cyc("R11 oe back");

    // R1: deselect on start cycles
    cstb_n = 0; ce3_n = 1; addr = 6'd1;
    cyc("R1 deselect ce3");
    cstb_n = 1; ce3_n = 0; adv_n = 0;
    cyc("R7 stays deselected"); cyc("R7 stays deselected");
    pstb_n = 0; ce1_n = 1; gw_n = 0; dq_in = 36'h0;
    cyc("R7 R3 pstb ignored while deselected");
    pstb_n = 1; ce1_n = 0; gw_n = 1; adv_n = 1;
    pstb_n = 0; ce2 = 0; addr = 6'd3;
    cyc("R1 deselect ce2");
    pstb_n = 0; ce2 = 1; addr = 6'd3;
    cyc("R1 reselect read");
    pstb_n = 1;

    // R12: sleep mid-burst
    pstb_n = 0; addr = 6'd20;
    cyc("R12 start");
    pstb_n = 1; adv_n = 0;
    cyc("R12 step");
    sleep = 1; cstb_n = 0; gw_n = 0; addr = 6'd40; dq_in = 36'h0_DEAD_BEEF;
    cyc("R12 asleep"); cyc("R12 asleep"); cyc("R12 asleep");
    sleep = 0;
    cyc("R12 wake edge ignored");
    quiet();
    cyc("R12 resume burst");
    adv_n = 0;
    cyc("R12 resume step");
    adv_n = 1; pstb_n = 0; addr = 6'd40;
    cyc("R12 array untouched");
    pstb_n = 1;
    cyc("R10 final");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule